// File: doc/BRIEF.md
# EDID fetch and checksum verifier

This block fetches the display identification data from a sink over an abstract sideband port that carries one byte per transaction. On a start pulse it first reads the extension-count byte of the base block. It then reads the 128-byte base block and checks it. If the extension count is nonzero, it also reads and checks the first extension block, which occupies offsets 128 to 255. A block passes when the 8-bit wrapping sum of its 128 bytes is zero.

A transaction error or a bad checksum ends the current attempt. The block then restarts the whole fetch, with at most three attempts in total. After a good fetch it reads the sink's test-request register. When the EDID-read test bit is set there, the block writes the checksum byte of the last block read to the sink's test-checksum register, then writes the response code to the test-response register.

The result is a one-cycle `done` or `error` pulse. The extension-present flag and the reported checksum byte are held after the pulse.

Top module: `edid_fetch`

## Requirements
- R1: After reset, `done`, `error`, `sb_req`, `ext_present` are 0 and `test_csum` is 0x00.
- R2: Every EDID transaction has `sb_space`=0 and `sb_dev`=0x50. Sink test-register transactions have `sb_space`=1. Writes occur only with `sb_space`=1.
- R3: An attempt starts with a read of EDID offset 126. It continues with reads of offsets 0 to 127 in ascending order. When the byte read at offset 126 is nonzero, reads of offsets 128 to 255 in ascending order follow.
- R4: A block whose 128 bytes do not sum to 0 modulo 256 ends the attempt. No further transaction of that attempt is issued.
- R5: A transaction acknowledged with `sb_err`=1 ends the attempt, whatever its kind.
- R6: A failed attempt restarts the fetch at offset 126. After the third failed attempt, `error` pulses and no `done` follows.
- R7: After the blocks pass, the block reads sink register 0x30. If bit 2 of that byte is 1, it writes the checksum byte to register 0x31 and then writes 0x01 to register 0x32. If bit 2 is 0, it writes nothing.
- R8: At `done` and until the next accepted start, `ext_present` equals (byte at offset 126 != 0). Over the same span, `test_csum` equals byte 127 of the last block read: offset 127, or offset 255 when an extension is present.
- R9: `sb_req` stays high, with address, space, write flag and write data stable, until `sb_ack`. It drops in the cycle after the acknowledge, so only one transaction is ever outstanding.
- R10: `done` and `error` last one cycle each and never occur together. The pulse comes one cycle after the final acknowledge, and the block issues no request until the next start.
- R11: A start pulse while a fetch is in progress has no effect on the transaction sequence or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fetch (accepted only when idle) |
| sb_req | output | 1 | Sideband transaction request |
| sb_write | output | 1 | 1 = write, 0 = read |
| sb_space | output | 1 | 0 = EDID device, 1 = sink test registers |
| sb_dev | output | 7 | Device address for EDID transactions |
| sb_addr | output | 8 | Byte offset or register address |
| sb_wdata | output | 8 | Write data |
| sb_ack | input | 1 | Transaction acknowledge |
| sb_err | input | 1 | Transaction failed, valid with `sb_ack` |
| sb_rdata | input | 8 | Read data, valid with `sb_ack` |
| done | output | 1 | Successful fetch pulse |
| error | output | 1 | Fetch failed after all attempts |
| ext_present | output | 1 | Extension block was flagged |
| test_csum | output | 8 | Checksum byte of the last block read |

## Verification
Each request is compared with the next entry of the bench model's expected transaction list. The comparison happens in the cycle the responder raises acknowledge, which is after a varied 0 to 2 cycle wait. A new request is due one cycle after the acknowledge has been taken.

The `done` or `error` pulse is due exactly one cycle after the final acknowledge. The bench counts cycles from that acknowledge and checks that the count is one when the pulse appears. It also checks that the pulse kind matches the model's outcome.

Five cycles after `done`, the held flag and checksum byte are sampled again. While the block is idle, the request line is checked on every cycle.

// File: rtl/edid_fetch.sv
module edid_fetch #(
  parameter logic [6:0] EDID_DEV   = 7'h50,
  parameter int         MAX_TRIES  = 3,
  parameter logic [7:0] EXT_OFS    = 8'd126,
  parameter logic [7:0] TREQ_ADDR  = 8'h30,
  parameter logic [7:0] TCSUM_ADDR = 8'h31,
  parameter logic [7:0] TRESP_ADDR = 8'h32,
  parameter int         TREQ_BIT   = 2,
  parameter logic [7:0] RESP_CODE  = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       sb_req,
  output logic       sb_write,
  output logic       sb_space,
  output logic [6:0] sb_dev,
  output logic [7:0] sb_addr,
  output logic [7:0] sb_wdata,
  input  logic       sb_ack,
  input  logic       sb_err,
  input  logic [7:0] sb_rdata,
  output logic       done,
  output logic       error,
  output logic       ext_present,
  output logic [7:0] test_csum
);
  localparam int TW = (MAX_TRIES > 2) ? $clog2(MAX_TRIES) : 1;

  typedef enum logic [2:0] {ST_IDLE, ST_EXT, ST_BLK, ST_TREQ, ST_TCS, ST_TRSP} st_t;

  st_t           st;
  logic          pend, blk;
  logic [6:0]    idx;
  logic [7:0]    sum;
  logic [TW-1:0] tries;

  wire       beat  = pend & sb_ack;
  wire [7:0] nsum  = sum + sb_rdata;
  wire       last  = (idx == 7'd127);
  wire       bad   = sb_err | ((st == ST_BLK) && last && (nsum != 8'd0));

  assign sb_req   = pend;
  assign sb_space = (st == ST_TREQ) || (st == ST_TCS) || (st == ST_TRSP);
  assign sb_write = (st == ST_TCS) || (st == ST_TRSP);
  assign sb_dev   = sb_space ? 7'd0 : EDID_DEV;
  assign sb_wdata = (st == ST_TCS) ? test_csum : ((st == ST_TRSP) ? RESP_CODE : 8'd0);

  always_comb begin
    case (st)
      ST_EXT:  sb_addr = EXT_OFS;
      ST_BLK:  sb_addr = {blk, idx};
      ST_TREQ: sb_addr = TREQ_ADDR;
      ST_TCS:  sb_addr = TCSUM_ADDR;
      ST_TRSP: sb_addr = TRESP_ADDR;
      default: sb_addr = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      pend        <= 1'b0;
      blk         <= 1'b0;
      idx         <= 7'd0;
      sum         <= 8'd0;
      tries       <= '0;
      done        <= 1'b0;
      error       <= 1'b0;
      ext_present <= 1'b0;
      test_csum   <= 8'd0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      if (st == ST_IDLE) begin
        if (start) begin
          st          <= ST_EXT;
          tries       <= '0;
          ext_present <= 1'b0;
          test_csum   <= 8'd0;
        end
      end else if (!pend) begin
        pend <= 1'b1;
      end else if (beat) begin
        pend <= 1'b0;
        if (bad) begin
          if (tries == TW'(MAX_TRIES - 1)) begin
            error <= 1'b1;
            st    <= ST_IDLE;
          end else begin
            tries <= tries + 1'b1;
            st    <= ST_EXT;
          end
        end else begin
          case (st)
            ST_EXT: begin
              ext_present <= (sb_rdata != 8'd0);
              st          <= ST_BLK;
              blk         <= 1'b0;
              idx         <= 7'd0;
              sum         <= 8'd0;
            end
            ST_BLK: begin
              if (last) begin
                test_csum <= sb_rdata;
                if (!blk && ext_present) begin
                  blk <= 1'b1;
                  idx <= 7'd0;
                  sum <= 8'd0;
                end else begin
                  st <= ST_TREQ;
                end
              end else begin
                idx <= idx + 7'd1;
                sum <= nsum;
              end
            end
            ST_TREQ: begin
              if (sb_rdata[TREQ_BIT]) st <= ST_TCS;
              else begin
                done <= 1'b1;
                st   <= ST_IDLE;
              end
            end
            ST_TCS:  st <= ST_TRSP;
            ST_TRSP: begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/edid_fetch_chk.sv
module edid_fetch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sb_req,
  input logic       sb_write,
  input logic       sb_space,
  input logic [6:0] sb_dev,
  input logic [7:0] sb_addr,
  input logic [7:0] sb_wdata,
  input logic       sb_ack,
  input logic       done,
  input logic       error
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req && !sb_ack |=> sb_req);

  assert_fields_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req && !sb_ack |=> $stable(sb_addr) && $stable(sb_space) && $stable(sb_write) && $stable(sb_wdata));

  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req && sb_ack |=> !sb_req);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done || error |=> !done && !error);

  assert_idle_after_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done || error |-> !sb_req);

  assert_write_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req && sb_write |-> sb_space);

  assert_edid_dev_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req && !sb_space |-> sb_dev == 7'h50);

  always @(posedge clk) begin
    if (rst_n) assert_exclusive_R10: assert (!(done && error));
  end
endmodule

bind edid_fetch edid_fetch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sb_req(sb_req), .sb_write(sb_write),
  .sb_space(sb_space), .sb_dev(sb_dev), .sb_addr(sb_addr),
  .sb_wdata(sb_wdata), .sb_ack(sb_ack), .done(done), .error(error)
);

// File: tb/sim_edid_fetch.sv
module sim_edid_fetch;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic sb_req, sb_write, sb_space, sb_ack = 1'b0, sb_err = 1'b0;
  logic [6:0] sb_dev;
  logic [7:0] sb_addr, sb_wdata, sb_rdata = 8'd0, test_csum;
  logic done, error, ext_present;

  always #(CLK_PERIOD/2) clk = ~clk;

  edid_fetch u0 (.clk(clk), .rst_n(rst_n), .start(start), .sb_req(sb_req),
    .sb_write(sb_write), .sb_space(sb_space), .sb_dev(sb_dev), .sb_addr(sb_addr),
    .sb_wdata(sb_wdata), .sb_ack(sb_ack), .sb_err(sb_err), .sb_rdata(sb_rdata),
    .done(done), .error(error), .ext_present(ext_present), .test_csum(test_csum));

  typedef struct packed {logic sp; logic wr; logic [7:0] a; logic [7:0] d;} txn_t;

  logic [7:0] mem [256];
  logic [7:0] treq_val;
  int err_at, k_bad, g0, b0base, mg, mb0;
  bit ext_bad, exp_ok, exp_ext;
  logic [7:0] exp_cs;
  txn_t q[$];
  int qi = 0, gcnt = 0, b0cnt = 0, ends = 0, started = 0, since_ack = 0, w = 0;
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input int a, input int b0);
    logic [7:0] v;
    v = mem[a];
    if (a == 5 && b0 <= k_bad) v ^= 8'h01;
    if (ext_bad && a == 200) v ^= 8'h01;
    return v;
  endfunction

  task automatic put(input bit sp, input bit wr, input int a, input int d, output bit e);
    txn_t t;
    t.sp = sp; t.wr = wr; t.a = 8'(a); t.d = 8'(d);
    q.push_back(t);
    e = (mg == err_at);
    mg++;
  endtask

  task automatic build();
    bit e, abort, ext;
    int s;
    logic [7:0] cs;
    mg = 0; mb0 = 0; exp_ok = 0;
    for (int att = 0; att < 3 && !exp_ok; att++) begin
      abort = 0;
      put(0, 0, 126, 0, e);
      if (e) continue;
      ext = (mem[126] != 0);
      for (int b = 0; b < 2 && !abort; b++) begin
        if (b == 1 && !ext) break;
        if (b == 0) mb0++;
        s = 0;
        for (int i = 0; i < 128 && !abort; i++) begin
          put(0, 0, b*128 + i, 0, e);
          if (e) abort = 1;
          s += byte_at(b*128 + i, mb0);
        end
        if (!abort && (s % 256) != 0) abort = 1;
      end
      if (abort) continue;
      put(1, 0, 8'h30, 0, e);
      if (e) continue;
      cs = ext ? mem[255] : mem[127];
      if (treq_val[2]) begin
        put(1, 1, 8'h31, cs, e);
        if (e) continue;
        put(1, 1, 8'h32, 8'h01, e);
        if (e) continue;
      end
      exp_ok = 1; exp_ext = ext; exp_cs = cs;
    end
  endtask

  task automatic fill(input logic [7:0] ext_cnt);
    int s0, s1;
    s0 = 0; s1 = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i*7 + 3);
    mem[126] = ext_cnt;
    for (int i = 0; i < 127; i++) s0 += mem[i];
    for (int i = 128; i < 255; i++) s1 += mem[i];
    mem[127] = 8'(256 - (s0 % 256));
    mem[255] = 8'(256 - (s1 % 256));
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      since_ack++;
      if (ends == started) chk(!sb_req, "R10", "request while idle", sb_req, 0);
      if (done || error) begin
        chk(qi == q.size(), "R3", "expected transactions left", q.size() - qi, 0);
        chk(since_ack == 1, "R10", "cycles from last ack to pulse", since_ack, 1);
        chk(done == exp_ok && error == !exp_ok, exp_ok ? "R6" : "R6", "done/error outcome", {done, error}, {exp_ok, !exp_ok});
        if (done) begin
          chk(ext_present == exp_ext, "R8", "ext_present at done", ext_present, exp_ext);
          chk(test_csum == exp_cs, "R8", "test_csum at done", test_csum, exp_cs);
        end
        ends++;
      end
      if (sb_ack) begin
        sb_ack = 1'b0; sb_err = 1'b0;
        w = gcnt % 3;
      end else if (sb_req) begin
        if (w > 0) w--;
        else begin
          if (qi >= q.size()) chk(0, "R3", "unexpected transaction addr", sb_addr, 0);
          else begin
            chk({sb_space, sb_write, sb_addr, sb_wdata} == q[qi], q[qi].sp ? "R7" : "R3",
                "transaction {sp,wr,addr,wdata}", {sb_space, sb_write, sb_addr, sb_wdata}, q[qi]);
            qi++;
          end
          if (!sb_space) chk(sb_dev == 7'h50, "R2", "EDID device address", sb_dev, 7'h50);
          sb_err = ((gcnt - g0) == err_at);
          gcnt++;
          if (!sb_space) begin
            if (sb_addr == 8'd0) b0cnt++;
            sb_rdata = byte_at(int'(sb_addr), b0cnt - b0base);
          end else sb_rdata = (!sb_write && sb_addr == 8'h30) ? treq_val : 8'h00;
          sb_ack = 1'b1;
          since_ack = 0;
        end
      end
    end
  end

  task automatic run_case(input logic [7:0] ext_cnt, input logic [7:0] treq, input int e_at,
                          input int kb, input bit xb, input bit dbl);
    int n0, e0;
    treq_val = treq; err_at = e_at; k_bad = kb; ext_bad = xb;
    fill(ext_cnt);
    g0 = gcnt; b0base = b0cnt; n0 = q.size(); e0 = ends;
    build();
    @(negedge clk);
    started++;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (dbl) begin
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (ends == e0) @(negedge clk);
    if (dbl) chk(gcnt - g0 == q.size() - n0, "R11", "transactions after busy start", gcnt - g0, q.size() - n0);
    repeat (5) @(negedge clk);
    if (exp_ok) begin
      chk(ext_present == exp_ext, "R8", "ext_present held", ext_present, exp_ext);
      chk(test_csum == exp_cs, "R8", "test_csum held", test_csum, exp_cs);
    end
    chk(!sb_req && !done && !error, "R10", "quiet after result", {sb_req, done, error}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !error && !sb_req && !ext_present && test_csum == 8'h00, "R1", "reset outputs",
        {done, error, sb_req, ext_present, test_csum}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case(8'd0, 8'h00, -1, 0, 0, 0);   // R3 R8 base only
    run_case(8'd1, 8'h04, -1, 0, 0, 0);   // R7 extension, test bit set
    run_case(8'd0, 8'h00, -1, 1, 0, 0);   // R4 R6 bad base first attempt
    run_case(8'd0, 8'h00, -1, 3, 0, 0);   // R4 R6 bad base every attempt
    run_case(8'd2, 8'h00, 140, 0, 0, 0);  // R5 error inside extension block
    run_case(8'd1, 8'h04, -1, 0, 1, 0);   // R4 bad extension every attempt
    run_case(8'd0, 8'h04, -1, 0, 0, 1);   // R11 R7 busy start ignored
    run_case(8'd0, 8'h00, 0, 0, 0, 0);    // R5 error on extension-count read
    run_case(8'd0, 8'h04, 131, 0, 0, 0);  // R5 error on response write
    run_case(8'd1, 8'hFB, -1, 0, 0, 0);   // R7 test bit clear
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule